// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Read Responder

This block models a 64-word by 16-bit serial EEPROM that a host reaches only through two 32-bit registers. Through the serial control register, software moves the clock, select and data-in lines by writing bits and reads the data-out line back. The block follows the clock transitions those writes create. It collects a 9-bit command made of a 3-bit opcode and a 6-bit word address. When the opcode is a read, it streams the addressed word out most significant bit first and carries on into the following words.

The second register is a one-shot word fetch. The host writes an address with a start flag. One cycle later the word appears in the upper half of the register, and a done flag is set.

The contents are fixed when reset is released. The three lowest words carry the station address taken from `macAddr`. The words in between are a computed fill pattern. The last word is a checksum that brings the 16-bit sum of all 64 words to a fixed signature. Reset is synchronous and active low. `macAddr` is sampled while reset is held.

Top module: `mw_eeprom_top`

## Requirements
- R1: Reading the serial control register gives bit 8 (present) = 1, bit 7 (grant) = 1 and bit 3 = data-out. It also gives the last written values of bit 0 (clock), bit 1 (select), bit 2 (data-in), bits 5:4 (write enable) and bit 6 (request). All other bits read 0. After reset the stored bits are 0 and data-out is 1, so the register reads 0x188.
- R2: A write to the serial control register whose bit 0 equals the stored clock bit leaves the serial state unchanged, whatever the other bits hold.
- R3: A clock rising edge written with select (bit 1) low clears the command shift register, the bit counter, the output pointer and the read-active flag.
- R4: A clock rising edge with select high shifts data-in (bit 2) into the command register. On the 9th such bit, if no read is active, bits 8:6 are the opcode and bits 5:0 the address. Only opcode 3'b110 starts a read; any other opcode leaves data-out at 1.
- R5: Starting a read sets the output pointer to address×16−1. Every clock falling edge adds one. While reading, data-out is bit (15 − pointer[3:0]) of word pointer[9:4], so a stream runs MSB first into the next word and wraps from word 63 to word 0. Data-out is 1 when no read is active.
- R6: Once a read is active, further rising edges with select high never re-decode a command or stop the read.
- R7: Words 0–2 hold `macAddr` low byte first (word k = {byte 2k+1, byte 2k}, byte n = macAddr[8n+7:8n]). Word i for 3 ≤ i ≤ 62 is {i XOR 0x5A, i} (byte values). Word 63 makes the 16-bit sum of all 64 words equal 0xBABA.
- R8: A write to the direct-read register with bit 0 = 1 latches the address from bits 15:8 and clears done (bit 4). On the next cycle, bits 31:16 hold the word and done reads 1. Bit 0 always reads 0.
- R9: A direct read of an address above 0x3F returns data 0 with done set and the address echoed.
- R10: A direct-read write with bit 0 = 0 only updates the address field. The data and done fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; contents are built while low |
| macAddr | input | 48 | Station address, byte 0 in bits 7:0 |
| ctlWrEn | input | 1 | Write strobe for the serial control register |
| ctlWrData | input | 32 | Serial control write value |
| ctlRdData | output | 32 | Serial control read value |
| drdWrEn | input | 1 | Write strobe for the direct-read register |
| drdWrData | input | 32 | Direct-read write value |
| drdRdData | output | 32 | Direct-read read value |

## Verification
A write to the serial control register takes effect at the clock edge that accepts it. The read value, data-out included, is valid straight after that edge, so each bench write task returns at the following falling edge and the check samples there. A direct read needs two edges: the first latches the address and clears done, and the second loads the data and sets done. The bench samples once after each edge and expects done at 0 and then at 1. Streams are collected one bit per clock pulse, with data-in toggling during the rising edges. This exposes any re-decode while a read is running.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 6;
  localparam int NWORDS = 1 << ADDR_W;
  localparam int OP_W   = 3;
  localparam int CMD_W  = OP_W + ADDR_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int PTR_W  = ADDR_W + BIT_W;
  localparam int CNT_W  = 16;
  localparam int MAC_WORDS = 3;

  // serial control register bit positions
  localparam int SK_B  = 0;
  localparam int CS_B  = 1;
  localparam int DI_B  = 2;
  localparam int DO_B  = 3;
  localparam int GNT_B = 7;
  localparam int PRS_B = 8;
  localparam logic [31:0] KEEP_MASK = 32'h0000_0077;

  typedef struct packed {
    logic       skRise;
    logic       skFall;
    logic       serReset;
    logic       diBit;
    logic       drdStart;
    logic       drdWrite;
    logic [7:0] drdAddr;
  } mwStrobes_t;

  function automatic logic [WORD_W-1:0] padWord(input logic [ADDR_W-1:0] idx);
    logic [7:0] b;
    b = 8'(idx);
    return {b ^ 8'h5A, b};
  endfunction
endpackage

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       macAddr,
  input  logic [ADDR_W-1:0] serIdx,
  input  logic [ADDR_W-1:0] drdIdx,
  output logic [WORD_W-1:0] serWord,
  output logic [WORD_W-1:0] drdWord
);
  localparam int NPORTS = 2;

  logic [47:0]       macReg;
  logic [WORD_W-1:0] sumReg;
  logic [WORD_W-1:0] padSum;
  logic [ADDR_W-1:0] idxArr  [NPORTS];
  logic [WORD_W-1:0] wordArr [NPORTS];

  always_comb begin
    padSum = '0;
    for (int i = MAC_WORDS; i < NWORDS - 1; i++)
      padSum = padSum + padWord(ADDR_W'(i));
  end

  // contents are captured while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      macReg <= macAddr;
      sumReg <= SIGNATURE - macAddr[15:0] - macAddr[31:16] - macAddr[47:32] - padSum;
    end
  end

  assign idxArr[0] = serIdx;
  assign idxArr[1] = drdIdx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_comb begin
      if (idxArr[p] == ADDR_W'(0))                 wordArr[p] = macReg[15:0];
      else if (idxArr[p] == ADDR_W'(1))            wordArr[p] = macReg[31:16];
      else if (idxArr[p] == ADDR_W'(2))            wordArr[p] = macReg[47:32];
      else if (idxArr[p] == ADDR_W'(NWORDS - 1))   wordArr[p] = sumReg;
      else                                         wordArr[p] = padWord(idxArr[p]);
    end
  end

  assign serWord = wordArr[0];
  assign drdWord = wordArr[1];
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctlWrEn,
  input  logic [31:0] ctlWrData,
  input  logic        drdWrEn,
  input  logic [31:0] drdWrData,
  output mwStrobes_t  stb,
  output logic [31:0] ctlKeep
);
  logic skChange;

  assign skChange = ctlWrEn && (ctlWrData[SK_B] != ctlKeep[SK_B]);

  always_comb begin
    stb          = '0;
    stb.skRise   = skChange && ctlWrData[SK_B] && ctlWrData[CS_B];
    stb.serReset = skChange && ctlWrData[SK_B] && !ctlWrData[CS_B];
    stb.skFall   = skChange && !ctlWrData[SK_B];
    stb.diBit    = ctlWrData[DI_B];
    stb.drdWrite = drdWrEn;
    stb.drdStart = drdWrEn && drdWrData[0];
    stb.drdAddr  = drdWrData[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctlKeep <= '0;
    else if (ctlWrEn) ctlKeep <= ctlWrData & KEEP_MASK;
  end
endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter logic [OP_W-1:0] READ_OP = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mwStrobes_t        stb,
  input  logic [WORD_W-1:0] serWord,
  input  logic [WORD_W-1:0] drdWord,
  output logic [ADDR_W-1:0] serIdx,
  output logic [ADDR_W-1:0] drdIdx,
  output logic              doBit,
  output logic [7:0]        drdAddr,
  output logic              drdDone,
  output logic [WORD_W-1:0] drdData
);
  logic [CMD_W-1:0] cmdSr, cmdNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic [PTR_W-1:0] ptr;
  logic             reading;
  logic             pending;

  assign cmdNext = {cmdSr[CMD_W-2:0], stb.diBit};
  assign cntNext = bitCnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || stb.serReset) begin
      cmdSr   <= '0;
      bitCnt  <= '0;
      ptr     <= '0;
      reading <= 1'b0;
    end else if (stb.skRise) begin
      cmdSr  <= cmdNext;
      bitCnt <= cntNext;
      if (cntNext == CNT_W'(CMD_W) && !reading) begin
        ptr     <= PTR_W'({cmdNext[ADDR_W-1:0], {BIT_W{1'b0}}}) - PTR_W'(1);
        reading <= (cmdNext[CMD_W-1:ADDR_W] == READ_OP);
      end
    end else if (stb.skFall) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  assign serIdx = ptr[PTR_W-1:BIT_W];
  assign doBit  = !reading || serWord[~ptr[BIT_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drdAddr <= '0;
      drdDone <= 1'b0;
      drdData <= '0;
      pending <= 1'b0;
    end else begin
      if (pending) begin
        drdData <= (drdAddr[7:ADDR_W] == '0) ? drdWord : '0;
        drdDone <= 1'b1;
        pending <= 1'b0;
      end
      if (stb.drdWrite) drdAddr <= stb.drdAddr;
      if (stb.drdStart) begin
        drdDone <= 1'b0;
        pending <= 1'b1;
      end
    end
  end

  assign drdIdx = drdAddr[ADDR_W-1:0];

  assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.skRise || stb.skFall || stb.serReset) |=>
      ($stable(ptr) && $stable(bitCnt) && $stable(reading)));

  assert_cs_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.serReset |=> (!reading && bitCnt == '0));

  assert_fall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.skFall |=> (ptr == $past(ptr) + PTR_W'(1)));

  assert_hold_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && stb.skRise) |=> reading);

  assert_done_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !stb.drdStart) |=> drdDone);

  assert_addr_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.drdWrite && !stb.drdStart && !pending) |=> ($stable(drdData) && $stable(drdDone)));
endmodule

// File: rtl/mw_eeprom_top.sv
module mw_eeprom_top
  import mw_pkg::*;
#(
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA,
  parameter logic [OP_W-1:0]   READ_OP   = 3'b110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] macAddr,
  input  logic        ctlWrEn,
  input  logic [31:0] ctlWrData,
  output logic [31:0] ctlRdData,
  input  logic        drdWrEn,
  input  logic [31:0] drdWrData,
  output logic [31:0] drdRdData
);
  mwStrobes_t        stb;
  logic [31:0]       ctlKeep;
  logic [ADDR_W-1:0] serIdx, drdIdx;
  logic [WORD_W-1:0] serWord, drdWord, drdData;
  logic              doBit, drdDone;
  logic [7:0]        drdAddr;

  mw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .drdWrEn(drdWrEn), .drdWrData(drdWrData),
    .stb(stb), .ctlKeep(ctlKeep)
  );

  mw_datapath #(.READ_OP(READ_OP)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .serWord(serWord), .drdWord(drdWord),
    .serIdx(serIdx), .drdIdx(drdIdx), .doBit(doBit),
    .drdAddr(drdAddr), .drdDone(drdDone), .drdData(drdData)
  );

  mw_store #(.SIGNATURE(SIGNATURE)) u_store (
    .clk(clk), .rst_n(rst_n), .macAddr(macAddr),
    .serIdx(serIdx), .drdIdx(drdIdx),
    .serWord(serWord), .drdWord(drdWord)
  );

  always_comb begin
    ctlRdData        = ctlKeep;
    ctlRdData[DO_B]  = doBit;
    ctlRdData[GNT_B] = 1'b1;
    ctlRdData[PRS_B] = 1'b1;
  end

  assign drdRdData = {drdData, drdAddr, 3'b000, drdDone, 4'b0000};
endmodule

// File: tb/tb_mw_eeprom_top.sv
module tb_mw_eeprom_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SK = 32'h1, CS = 32'h2, DI = 32'h4;
  localparam logic [47:0] MAC = 48'h6655_4433_2211;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [47:0] macAddr = MAC;
  logic ctlWrEn = 1'b0, drdWrEn = 1'b0;
  logic [31:0] ctlWrData = '0, drdWrData = '0;
  logic [31:0] ctlRdData, drdRdData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_top dut (
    .clk(clk), .rst_n(rst_n), .macAddr(macAddr),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .drdWrEn(drdWrEn), .drdWrData(drdWrData), .drdRdData(drdRdData)
  );

  function automatic logic [15:0] expWord(input int i);
    logic [15:0] sum;
    logic [7:0] b;
    if (i == 0) return MAC[15:0];
    if (i == 1) return MAC[31:16];
    if (i == 2) return MAC[47:32];
    if (i == 63) begin
      sum = 16'h0;
      for (int k = 0; k < 63; k++) sum = sum + expWord(k);
      return 16'hBABA - sum;
    end
    b = 8'(i);
    return {b ^ 8'h5A, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctlWr(input logic [31:0] v);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    logic [31:0] d;
    d = b ? DI : 32'h0;
    ctlWr(CS | d);
    ctlWr(CS | SK | d);
    ctlWr(CS | d);
  endtask

  task automatic serialReset();
    ctlWr(32'h0);
    ctlWr(SK);
    ctlWr(32'h0);
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [5:0] addr);
    for (int k = 2; k >= 0; k--) sendBit(op[k]);
    for (int k = 5; k >= 0; k--) sendBit(addr[k]);
  endtask

  // collect n bits of data-out; data-in toggles on every rising edge
  task automatic streamBits(input int n, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      got = {got[30:0], ctlRdData[3]};
      ctlWr(CS | SK | ((k % 2 == 0) ? DI : 32'h0));
      ctlWr(CS);
    end
  endtask

  task automatic drdWr(input logic [31:0] v);
    @(negedge clk); drdWrEn = 1'b1; drdWrData = v;
    @(negedge clk); drdWrEn = 1'b0;
  endtask

  task automatic drdRead(input logic [7:0] a, output logic [31:0] r, output logic [31:0] early);
    drdWr({16'h0, a, 8'h01});
    early = drdRdData;
    @(negedge clk);
    r = drdRdData;
  endtask

  task automatic testReset();
    check("R1 reset readback", ctlRdData, 32'h188);
    check("R8 reset direct", drdRdData, 32'h0);
  endtask

  task automatic testReadback();
    ctlWr(32'hFFFF_FFFF);
    check("R1 all ones", ctlRdData, 32'h1FF);
    ctlWr(32'h76);
    check("R1 echo", ctlRdData, 32'h1FE);
  endtask

  task automatic testStream();
    logic [31:0] got;
    serialReset();
    sendCmd(3'b110, 6'd5);
    streamBits(32, got);
    check("R5 word5 then word6 (R4 R6)", got, {expWord(5), expWord(6)});
  endtask

  task automatic testWrap();
    logic [31:0] got;
    serialReset();
    sendCmd(3'b110, 6'd63);
    streamBits(32, got);
    check("R5 wrap 63 to 0", got, {expWord(63), expWord(0)});
  endtask

  task automatic testBadOp();
    logic [31:0] got;
    serialReset();
    sendCmd(3'b101, 6'd5);
    streamBits(16, got);
    check("R4 non-read opcode", got, 32'h0000_FFFF);
  endtask

  task automatic testCsReset();
    logic [31:0] got;
    serialReset();
    sendCmd(3'b110, 6'd10);
    streamBits(3, got);
    check("R5 partial", got, 32'(expWord(10) >> 13));
    ctlWr(32'h0);
    ctlWr(SK);
    check("R3 do idle after cs low edge", 32'(ctlRdData[3]), 32'h1);
    ctlWr(32'h0);
    sendCmd(3'b110, 6'd4);
    streamBits(16, got);
    check("R3 fresh command after reset", got, 32'(expWord(4)));
  endtask

  task automatic testNoEdge();
    logic [31:0] got;
    serialReset();
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    for (int k = 0; k < 4; k++) begin
      ctlWr(CS | DI);
      ctlWr(CS);
    end
    check("R2 not reading", 32'(ctlRdData[3]), 32'h1);
    for (int k = 5; k >= 0; k--) sendBit(k[0] == 1'b0);
    streamBits(16, got);
    check("R2 command unaffected", got, 32'(expWord(6'b010101)));
  endtask

  task automatic testContents();
    logic [31:0] r, e;
    logic [15:0] sum;
    drdRead(8'd0, r, e);
    check("R8 done cleared at start", 32'(e[4]), 32'h0);
    check("R7 mac word0 (R8)", r, {MAC[15:0], 8'd0, 8'h10});
    drdRead(8'd2, r, e);
    check("R7 mac word2", r[31:16], 32'(MAC[47:32]));
    drdRead(8'd40, r, e);
    check("R7 pad word40", r[31:16], 32'(expWord(40)));
    sum = 16'h0;
    for (int i = 0; i < 64; i++) begin
      drdRead(8'(i), r, e);
      sum = sum + r[31:16];
    end
    check("R7 signature sum", 32'(sum), 32'hBABA);
  endtask

  task automatic testOutOfRange();
    logic [31:0] r, e;
    drdRead(8'h40, r, e);
    check("R9 addr 0x40", r, {16'h0, 8'h40, 8'h10});
    drdRead(8'hFF, r, e);
    check("R9 addr 0xFF", r, {16'h0, 8'hFF, 8'h10});
  endtask

  task automatic testAddrOnly();
    logic [31:0] r, e;
    drdRead(8'd10, r, e);
    drdWr({16'h0, 8'd7, 8'h00});
    @(negedge clk);
    check("R10 address only", drdRdData, {expWord(10), 8'd7, 8'h10});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testStream();
    testWrap();
    testBadOp();
    testCsReset();
    testNoEdge();
    testContents();
    testOutOfRange();
    testAddrOnly();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule